// File: doc/BRIEF.md
# Flash Lock-Bit Clear Sequencer

This block is a host-side controller that carries out the "clear all block lock-bits" operation on a parallel NOR-style flash device. It reaches the device through a generic synchronous request/acknowledge bus master port. A one-cycle start pulse begins the operation. The controller then writes the two-cycle unlock command pair and polls the device status register until the device's internal write engine reports ready. It ranks the error bits by priority and condenses them into one 3-bit result code. After any reported error it issues a clear-status command. On every path it writes the read-array command last.

The result is presented with a one-cycle completion pulse and stays on `result` until the next operation finishes. A programmable poll limit bounds the polling phase, so a device that never becomes ready yields a timeout code instead of a hang. Start pulses that arrive while an operation is running are ignored.

Top module: `lkclr_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_req` are 0.
- R2: A start pulse while idle produces a bus write of 60h (setup) and then a bus write of D0h (confirm), both at address CMD_ADDR.
- R3: After the confirm write the controller issues reads (`bus_we`=0) at STAT_ADDR. It keeps reading while status bit 7 is 0 and ignores all other status bits on those reads.
- R4: On the first read with bit 7 = 1, status bit 3 = 1 gives result code 1 (voltage error). This applies whatever the values of bits 4 and 5.
- R5: With bit 7 = 1, bit 3 = 0, and bits 4 and 5 both 1, the result code is 2 (command-sequence error).
- R6: With bit 7 = 1, bit 3 = 0 and bit 5 = 1 but bit 4 = 0, the result code is 3 (lock-clear failure). Any other ready status, including bit 4 alone set, gives code 0 (success).
- R7: For result codes 1, 2 and 3, a write of 50h (clear status) comes before the final write. Codes 0 and 4 issue no 50h write.
- R8: Every operation ends with a write of FFh (read-array mode). After it, `done` pulses for exactly one cycle, and `result` holds the code until the next operation finishes.
- R9: Polling ends with result code 4 (timeout) at the busy read that brings the busy-read count to `poll_limit`. A limit of 0 acts as 1.
- R10: A start pulse while `busy` is 1 is ignored: no additional command sequence is issued.
- R11: A bus request stays asserted, with `bus_addr`, `bus_we` and `bus_wdata` unchanged, until the cycle in which `bus_ack` is 1. Then it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| poll_limit | input | TW | Maximum busy status reads before timeout |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 sequence, 3 lock-clear fail, 4 timeout |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data / command byte |
| bus_rdata | input | DW | Read data, valid with bus_ack on reads |
| bus_ack | input | 1 | Transaction acknowledge |

## Verification
The hardest situations to reach from the ports are the poll-exhaustion boundary and a busy status that already carries error bits. The bench's behavioural flash responder returns a scripted number of busy reads carrying bits 3, 4 and 5, followed by a scripted final status. Scripting more busy reads than `poll_limit`, including a limit of 0, drives the timeout edge. Other runs add acknowledge latency to exercise request holding, and send a second start pulse in the middle of a long poll.

// File: rtl/lkclr_pkg.sv
package lkclr_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_VOLT     = 3'd1,
    RES_SEQ      = 3'd2,
    RES_LOCKFAIL = 3'd3,
    RES_TIMEOUT  = 3'd4
  } lkc_res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONF, S_POLL, S_CLR, S_RDARR
  } lkc_state_e;
endpackage

// File: rtl/lkclr_bus_port.sv
module lkclr_bus_port #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          fin,
  output logic [DW-1:0] rd_q,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      fin       <= 1'b0;
      rd_q      <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_data;
      end else if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        fin     <= 1'b1;
        rd_q    <= bus_rdata;
      end
    end
  end

  // R11: request and its fields hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R2: a new transaction is never launched over an outstanding one
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    go |-> !bus_req && !fin);

  // R7: only the four command bytes are ever written
  a_r7_cmd_legal: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> (bus_wdata[7:0] == 8'h60 || bus_wdata[7:0] == 8'hD0 ||
                           bus_wdata[7:0] == 8'h50 || bus_wdata[7:0] == 8'hFF));
endmodule

// File: rtl/lkclr_status_decode.sv
module lkclr_status_decode
  import lkclr_pkg::*;
(
  input  logic [7:0] status,
  output logic       ready,
  output lkc_res_e   code
);
  always_comb begin
    ready = status[7];
    if (status[3])                  code = RES_VOLT;
    else if (status[4] && status[5]) code = RES_SEQ;
    else if (status[5])             code = RES_LOCKFAIL;
    else                            code = RES_OK;
  end
endmodule

// File: rtl/lkclr_poll_timer.sv
module lkclr_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [TW-1:0] limit,
  output logic          last
);
  localparam int CW = TW + 1;
  logic [TW-1:0] cnt;

  assign last = (CW'(cnt) + CW'(1)) >= CW'(limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= cnt + TW'(1);
  end

  // R9: the timer never advances past the busy read that ends polling
  a_r9_no_step_at_last: assert property (@(posedge clk) disable iff (rst)
    step |-> !last);
endmodule

// File: rtl/lkclr_seq.sv
module lkclr_seq
  import lkclr_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            DW        = 8,
  parameter int            TW        = 16,
  parameter logic [AW-1:0] CMD_ADDR  = '0,
  parameter logic [AW-1:0] STAT_ADDR = AW'(2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] poll_limit,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  lkc_state_e    state;
  logic          pend;
  lkc_res_e      err_q;
  logic          go, op_we, fin;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, rd_q;
  logic          st_ready, tm_last, tm_clr, tm_step;
  lkc_res_e      st_code;

  always_comb begin
    op_we   = 1'b1;
    op_addr = CMD_ADDR;
    op_data = DW'(CMD_RDARRAY);
    case (state)
      S_SETUP: op_data = DW'(CMD_SETUP);
      S_CONF:  op_data = DW'(CMD_CONFIRM);
      S_POLL:  begin op_we = 1'b0; op_addr = STAT_ADDR; op_data = '0; end
      S_CLR:   op_data = DW'(CMD_CLRSTAT);
      default: op_data = DW'(CMD_RDARRAY);
    endcase
  end

  assign go      = (state != S_IDLE) && !pend;
  assign tm_clr  = (state == S_CONF);
  assign tm_step = (state == S_POLL) && fin && !st_ready && !tm_last;
  assign busy    = (state != S_IDLE);

  lkclr_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .go(go), .go_we(op_we), .go_addr(op_addr), .go_data(op_data),
    .fin(fin), .rd_q(rd_q), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  lkclr_status_decode u_dec (.status(rd_q[7:0]), .ready(st_ready), .code(st_code));

  lkclr_poll_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tm_clr), .step(tm_step), .limit(poll_limit), .last(tm_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      pend   <= 1'b0;
      err_q  <= RES_OK;
      done   <= 1'b0;
      result <= 3'd0;
    end else begin
      done <= 1'b0;
      if (go) pend <= 1'b1;
      if (fin) pend <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_SETUP;
          err_q <= RES_OK;
        end
        S_SETUP: if (fin) state <= S_CONF;
        S_CONF:  if (fin) state <= S_POLL;
        S_POLL: if (fin) begin
          if (st_ready) begin
            err_q <= st_code;
            state <= (st_code == RES_OK) ? S_RDARR : S_CLR;
          end else if (tm_last) begin
            err_q <= RES_TIMEOUT;
            state <= S_RDARR;
          end
        end
        S_CLR: if (fin) state <= S_RDARR;
        S_RDARR: if (fin) begin
          state  <= S_IDLE;
          done   <= 1'b1;
          result <= err_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8: leaving the busy phase always reports completion
  a_r8_end_reports: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  // R7: clear-status is issued only for a device-reported error
  a_r7_clr_only_err: assert property (@(posedge clk) disable iff (rst)
    state == S_CLR |-> (err_q == RES_VOLT || err_q == RES_SEQ || err_q == RES_LOCKFAIL));
endmodule

// File: tb/lkclr_seq_bench.sv
`timescale 1ns/1ps
module lkclr_seq_bench;
  localparam int AW = 24, DW = 8, TW = 16;
  localparam logic [AW-1:0] CMDA = 24'h000000, STATA = 24'h000002;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [TW-1:0] poll_limit = 16'd50;
  logic busy, done, bus_req, bus_we, bus_ack = 1'b0;
  logic [2:0] result;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;

  always #2.5 clk = ~clk;

  lkclr_seq #(.AW(AW), .DW(DW), .TW(TW), .CMD_ADDR(CMDA), .STAT_ADDR(STATA)) u_lkclr_seq (
    .clk(clk), .rst(rst), .start(start), .poll_limit(poll_limit), .busy(busy), .done(done),
    .result(result), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // behavioural flash responder
  int lat = 0, busy_n = 0, w = 0, wcnt = 0, rcnt = 0, addr_err = 0, stab_err = 0;
  logic [7:0] fin_stat = 8'h80;
  logic [7:0] wlog [0:7];
  always @(posedge clk) begin
    if (start && !busy) begin wcnt = 0; rcnt = 0; addr_err = 0; end
    if (rst) begin bus_ack <= 1'b0; w = 0; end
    else if (bus_req && !bus_ack) begin
      if (w >= lat) begin
        bus_ack <= 1'b1; w = 0;
        if (bus_we) begin
          if (wcnt < 8) wlog[wcnt] = bus_wdata;
          wcnt++;
          if (bus_addr != CMDA) addr_err++;
        end else begin
          bus_rdata <= (rcnt < busy_n) ? 8'h38 : fin_stat;
          rcnt++;
          if (bus_addr != STATA) addr_err++;
        end
      end else w++;
    end else bus_ack <= 1'b0;
  end

  // request stability monitor
  logic pw = 1'b0, pwe = 1'b0;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0;
  always @(posedge clk) begin
    if (start && !busy) stab_err = 0;
    if (pw && !(bus_req && bus_we == pwe && bus_addr == pa && bus_wdata == pd)) stab_err++;
    pw = bus_req && !bus_ack; pwe = bus_we; pa = bus_addr; pd = bus_wdata;
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int cyc = 0;
    seen = 1'b0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    seen = done;
  endtask

  task automatic run_case(input int bn, input logic [7:0] st, input int lim, input int lt,
                          input logic [2:0] exp, input string tag);
    bit seen;
    int nw, nr, le;
    logic [7:0] ew [0:3];
    busy_n = bn; fin_stat = st; poll_limit = TW'(lim); lat = lt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(seen);
    chk(seen, {tag, " done"}, seen, 1);
    chk(result == exp, {tag, " result"}, result, exp);
    ew[0] = 8'h60; ew[1] = 8'hD0;
    if (exp >= 3'd1 && exp <= 3'd3) begin ew[2] = 8'h50; ew[3] = 8'hFF; nw = 4; end
    else begin ew[2] = 8'hFF; nw = 3; end
    chk(wcnt == nw, {tag, " write count"}, wcnt, nw);
    for (int i = 0; i < nw && i < wcnt; i++)
      chk(wlog[i] == ew[i], {tag, " write order"}, wlog[i], ew[i]);
    le = (lim == 0) ? 1 : lim;
    nr = (exp == 3'd4) ? le : bn + 1;
    chk(rcnt == nr, {tag, " status reads"}, rcnt, nr);
    chk(addr_err == 0, {tag, " addresses"}, addr_err, 0);
    @(negedge clk);
    chk(!done && result == exp, {tag, " R8 pulse/hold"}, {done, result}, {1'b0, exp});
  endtask

  task automatic t_reset;
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    chk(!bus_req, "R1 bus_req", bus_req, 0);
  endtask

  task automatic t_ignore_start;
    bit seen;
    busy_n = 20; fin_stat = 8'h80; poll_limit = 16'd50; lat = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    chk(busy, "R10 busy mid-run", busy, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(seen);
    chk(seen && result == 3'd0, "R10 result", result, 0);
    chk(wcnt == 3 && wlog[0] == 8'h60 && wlog[1] == 8'hD0 && wlog[2] == 8'hFF,
        "R10 single sequence", wcnt, 3);
    chk(rcnt == 21, "R10 reads", rcnt, 21);
    repeat (10) @(negedge clk);
    chk(!busy && !bus_req, "R10 no restart", {busy, bus_req}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    run_case(2, 8'h80, 50, 0, 3'd0, "R2 R3 R6 success");
    run_case(1, 8'hB8, 50, 0, 3'd1, "R4 R7 voltage priority");
    run_case(0, 8'hB0, 50, 0, 3'd2, "R5 R7 sequence");
    run_case(3, 8'hA0, 50, 0, 3'd3, "R6 R7 lock fail");
    run_case(1, 8'h90, 50, 0, 3'd0, "R6 bit4 alone ok");
    run_case(100, 8'h80, 5, 0, 3'd4, "R9 timeout");
    run_case(100, 8'h80, 0, 0, 3'd4, "R9 zero limit");
    run_case(4, 8'h80, 5, 0, 3'd0, "R9 ready before limit");
    run_case(3, 8'hA0, 50, 3, 3'd3, "R11 slow ack");
    chk(stab_err == 0, "R11 request stable", stab_err, 0);
    t_ignore_start();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end
endmodule